// File: doc/BRIEF.md
# I/O-port byte mailbox with link-alive gating

This block joins an 8-bit CPU I/O bus to an external controller through a pair of one-byte channels. Inbound bytes go from the controller to the CPU, and outbound bytes go from the CPU to the controller. Each channel holds a single byte and keeps its own full flag and empty flag. A CPU read of the decoded port takes the inbound byte. A CPU write places a byte in the outbound channel. When the needed channel is not ready, the block holds the bus cycle with an active-low wait request until the controller fills or drains the channel.

Every transfer depends on a two-sided liveness check. The controller reports its own alive bit. The block keeps a local alive bit and a connected state. A connect request succeeds only while the controller already reports alive, and it sets the local alive bit in the same cycle. A drop request clears both.

An access made while not connected completes at once and moves no data. An access made while connected, but with the link no longer alive, also clears the connected state. In both cases a read returns 0x00 and a write is thrown away. The read-data-valid output is raised only for reads that really came from the controller. While it is low, other devices may drive the bus.

Top module: `io_byte_mailbox`

## Requirements
- R1: The port is hit when (cpu_addr & 16'h00FF) == 16'h00EF, so the upper address byte does not matter. An access to any other address is ignored: no byte is popped, no byte is stored, cpu_rdata_vld stays 0 and cpu_wait_n stays 1.
- R2: After reset, the outputs are as follows. ctl_in_ready is 1 (inbound channel empty) and ctl_out_valid is 0 (outbound channel not full). cpu_wait_n is 1. cpu_rdata_vld, link_up and cpu_alive are all 0.
- R3: A connected read whose inbound channel is full completes on the first edge it is seen. The edge after completion presents the byte on cpu_rdata with cpu_rdata_vld = 1, and the inbound channel becomes empty (ctl_in_ready = 1).
- R4: A connected write whose outbound channel is empty stores cpu_wdata. After the edge, ctl_out_valid = 1 with that byte on ctl_out_data. Valid and data stay unchanged until the controller takes the byte with ctl_out_ready.
- R5: A connected read with the inbound channel empty drives cpu_wait_n = 0 from the edge after the request is seen. The read completes once the controller has pushed a byte, and it returns that byte.
- R6: A connected write with the outbound channel full drives cpu_wait_n = 0 until the controller drains the channel. The write is then stored, so both bytes reach the controller in order.
- R7: A link_connect pulse sets link_up and cpu_alive only if ctl_alive is 1 during that cycle. Otherwise the pulse changes nothing.
- R8: A link_drop pulse clears link_up and cpu_alive. A drop takes priority over a connect in the same cycle.
- R9: If an access, including one already waiting, is seen while link_up = 1 and ctl_alive = 0, the block does three things. It clears link_up, it completes the access without waiting, and it moves no data. A read returns cpu_rdata = 8'h00 with cpu_rdata_vld = 0, and a write leaves ctl_out_valid at 0.
- R10: An access while link_up = 0 completes without waiting and moves no data. The inbound byte stays in place, a read returns 8'h00 with cpu_rdata_vld = 0, and a write is discarded.
- R11: One bus cycle moves at most one byte. Holding cpu_rd high after a read has completed does not pop a byte that arrives later. cpu_rdata keeps the first byte until cpu_rd drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU I/O address |
| cpu_rd | input | 1 | CPU I/O read, held for the bus cycle |
| cpu_wr | input | 1 | CPU I/O write, held for the bus cycle |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data (0x00 when not valid) |
| cpu_rdata_vld | output | 1 | Read data is genuine and may be driven on the bus |
| cpu_wait_n | output | 1 | Active-low wait request |
| link_connect | input | 1 | Connect request pulse |
| link_drop | input | 1 | Disconnect request pulse |
| ctl_alive | input | 1 | Controller alive bit |
| link_up | output | 1 | Connected state |
| cpu_alive | output | 1 | Local (CPU-side) alive bit |
| ctl_in_valid | input | 1 | Controller offers an inbound byte |
| ctl_in_data | input | 8 | Inbound byte |
| ctl_in_ready | output | 1 | Inbound channel empty |
| ctl_out_valid | output | 1 | Outbound channel full |
| ctl_out_data | output | 8 | Outbound byte |
| ctl_out_ready | input | 1 | Controller takes the outbound byte |

## Verification
The bench drives reads that arrive before the controller's byte and writes that find the outbound channel still occupied. A design with a wrong wait rule would return stale data or overwrite a byte that has not been taken. The bench also removes the controller's alive bit while a read is stalled. A design that ignored liveness would stay in wait forever or mark the zero result valid. The bench also holds a finished read across a fresh inbound byte, which catches a design that pops twice in one bus cycle. It probes addresses that differ only in the upper byte, and ones that differ in the low byte, to catch a decode that is too loose or too strict.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  localparam int unsigned CH_IN  = 0;
  localparam int unsigned CH_OUT = 1;
  localparam int unsigned CH_NUM = 2;
endpackage

// File: rtl/mbox_slot.sv
module mbox_slot #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_vld,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          full,
  output logic          empty,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full  <= 1'b0;
      empty <= 1'b1;
      data  <= '0;
    end else if (push_vld && empty) begin
      data  <= push_data;
      full  <= 1'b1;
      empty <= 1'b0;
    end else if (pop && full) begin
      full  <= 1'b0;
      empty <= 1'b1;
    end
  end
endmodule

// File: rtl/mbox_link.sv
module mbox_link (
  input  logic clk,
  input  logic rst,
  input  logic connect_req,
  input  logic drop_req,
  input  logic peer_alive,
  input  logic access_fail,
  output logic link_up,
  output logic local_alive,
  output logic alive_ok
);
  always_ff @(posedge clk) begin
    if (rst) begin
      link_up     <= 1'b0;
      local_alive <= 1'b0;
    end else if (drop_req) begin
      link_up     <= 1'b0;
      local_alive <= 1'b0;
    end else if (access_fail) begin
      link_up <= 1'b0;
    end else if (connect_req && peer_alive) begin
      link_up     <= 1'b1;
      local_alive <= 1'b1;
    end
  end

  assign alive_ok = peer_alive & local_alive;
endmodule

// File: rtl/mbox_access.sv
module mbox_access
  import mbox_pkg::*;
#(
  parameter int unsigned     AW       = 16,
  parameter int unsigned     DW       = 8,
  parameter logic [AW-1:0]   SEL_ADDR = 16'h00EF,
  parameter logic [AW-1:0]   SEL_MASK = 16'h00FF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic          link_up,
  input  logic          alive_ok,
  input  logic          in_full,
  input  logic [DW-1:0] in_data,
  input  logic          out_empty,
  output logic          in_pop,
  output logic          out_push,
  output logic          access_fail,
  output logic          wait_n,
  output logic [DW-1:0] rdata,
  output logic          rdata_vld
);
  acc_kind_e kind;
  logic      hit, active, usable, chan_rdy, complete;
  logic      done_q;

  assign hit = ((addr & SEL_MASK) == (SEL_ADDR & SEL_MASK));

  always_comb begin
    kind = ACC_IDLE;
    if (hit && rd)      kind = ACC_READ;
    else if (hit && wr) kind = ACC_WRITE;
  end

  assign active      = (kind != ACC_IDLE) && !done_q;
  assign usable      = link_up && alive_ok;
  assign chan_rdy    = (kind == ACC_READ) ? in_full : out_empty;
  assign complete    = active && (!usable || chan_rdy);
  assign in_pop      = active && usable && (kind == ACC_READ) && in_full;
  assign out_push    = active && usable && (kind == ACC_WRITE) && out_empty;
  assign access_fail = active && link_up && !alive_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q    <= 1'b0;
      wait_n    <= 1'b1;
      rdata     <= '0;
      rdata_vld <= 1'b0;
    end else begin
      wait_n <= !(active && usable && !chan_rdy);
      if (kind == ACC_IDLE) begin
        done_q    <= 1'b0;
        rdata     <= '0;
        rdata_vld <= 1'b0;
      end else if (complete) begin
        done_q <= 1'b1;
        if (kind == ACC_READ) begin
          rdata     <= usable ? in_data : '0;
          rdata_vld <= usable;
        end
      end
    end
  end
endmodule

// File: rtl/io_byte_mailbox.sv
module io_byte_mailbox
  import mbox_pkg::*;
#(
  parameter int unsigned   AW       = 16,
  parameter int unsigned   DW       = 8,
  parameter logic [AW-1:0] SEL_ADDR = 16'h00EF,
  parameter logic [AW-1:0] SEL_MASK = 16'h00FF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_rdata_vld,
  output logic          cpu_wait_n,
  input  logic          link_connect,
  input  logic          link_drop,
  input  logic          ctl_alive,
  output logic          link_up,
  output logic          cpu_alive,
  input  logic          ctl_in_valid,
  input  logic [DW-1:0] ctl_in_data,
  output logic          ctl_in_ready,
  output logic          ctl_out_valid,
  output logic [DW-1:0] ctl_out_data,
  input  logic          ctl_out_ready
);
  logic          s_push [CH_NUM];
  logic [DW-1:0] s_wdat [CH_NUM];
  logic          s_pop  [CH_NUM];
  logic          s_full [CH_NUM];
  logic          s_empty[CH_NUM];
  logic [DW-1:0] s_data [CH_NUM];

  logic in_pop, out_push, access_fail, alive_ok;

  assign s_push[CH_IN]  = ctl_in_valid;
  assign s_wdat[CH_IN]  = ctl_in_data;
  assign s_pop[CH_IN]   = in_pop;
  assign s_push[CH_OUT] = out_push;
  assign s_wdat[CH_OUT] = cpu_wdata;
  assign s_pop[CH_OUT]  = ctl_out_ready;

  for (genvar g = 0; g < CH_NUM; g++) begin : g_slot
    mbox_slot #(.DW(DW)) i_slot (
      .clk      (clk),
      .rst      (rst),
      .push_vld (s_push[g]),
      .push_data(s_wdat[g]),
      .pop      (s_pop[g]),
      .full     (s_full[g]),
      .empty    (s_empty[g]),
      .data     (s_data[g])
    );
  end

  assign ctl_in_ready  = s_empty[CH_IN];
  assign ctl_out_valid = s_full[CH_OUT];
  assign ctl_out_data  = s_data[CH_OUT];

  mbox_link i_link (
    .clk        (clk),
    .rst        (rst),
    .connect_req(link_connect),
    .drop_req   (link_drop),
    .peer_alive (ctl_alive),
    .access_fail(access_fail),
    .link_up    (link_up),
    .local_alive(cpu_alive),
    .alive_ok   (alive_ok)
  );

  mbox_access #(
    .AW(AW), .DW(DW), .SEL_ADDR(SEL_ADDR), .SEL_MASK(SEL_MASK)
  ) i_access (
    .clk        (clk),
    .rst        (rst),
    .addr       (cpu_addr),
    .rd         (cpu_rd),
    .wr         (cpu_wr),
    .link_up    (link_up),
    .alive_ok   (alive_ok),
    .in_full    (s_full[CH_IN]),
    .in_data    (s_data[CH_IN]),
    .out_empty  (s_empty[CH_OUT]),
    .in_pop     (in_pop),
    .out_push   (out_push),
    .access_fail(access_fail),
    .wait_n     (cpu_wait_n),
    .rdata      (cpu_rdata),
    .rdata_vld  (cpu_rdata_vld)
  );
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_rdata_vld,
  input logic          cpu_wait_n,
  input logic          link_connect,
  input logic          link_drop,
  input logic          ctl_alive,
  input logic          link_up,
  input logic          cpu_alive,
  input logic          ctl_out_valid,
  input logic [DW-1:0] ctl_out_data,
  input logic          ctl_out_ready
);
  // R5: stalling is only possible on a connected link
  p_wait_needs_link_r5: assert property (@(posedge clk) disable iff (rst)
    !cpu_wait_n |-> $past(link_up));

  // R9: genuine read data only comes over a connected link
  p_vld_needs_link_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_rdata_vld) |-> $past(link_up));

  // R7: a connection only forms while the controller is alive
  p_connect_peer_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(link_up) |-> ($past(ctl_alive) && $past(link_connect) && cpu_alive));

  // R8: a drop clears both state bits
  p_drop_clears_r8: assert property (@(posedge clk) disable iff (rst)
    link_drop |=> (!link_up && !cpu_alive));

  // R4: an offered outbound byte holds until taken
  p_out_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl_out_valid && !ctl_out_ready) |=> (ctl_out_valid && $stable(ctl_out_data)));
endmodule

bind io_byte_mailbox mbox_checker #(.DW(DW)) i_chk (.*);

// File: tb/test_io_byte_mailbox.sv
`timescale 1ns/1ps
module test_io_byte_mailbox;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = 16'h0000;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [7:0]  cpu_rdata;
  logic        cpu_rdata_vld, cpu_wait_n;
  logic        link_connect = 1'b0, link_drop = 1'b0, ctl_alive = 1'b0;
  logic        link_up, cpu_alive;
  logic        ctl_in_valid = 1'b0;
  logic [7:0]  ctl_in_data = 8'h00;
  logic        ctl_in_ready, ctl_out_valid;
  logic [7:0]  ctl_out_data;
  logic        ctl_out_ready = 1'b0;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  io_byte_mailbox i_io_byte_mailbox (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [15:0] port_addr(input logic [7:0] hi);
    return {hi, 8'hEF};
  endfunction

  task automatic pulse_connect();
    @(negedge clk); link_connect = 1'b1; @(negedge clk); link_connect = 1'b0;
  endtask

  task automatic pulse_drop();
    @(negedge clk); link_drop = 1'b1; @(negedge clk); link_drop = 1'b0;
  endtask

  task automatic ctl_push(input logic [7:0] b);
    @(negedge clk);
    while (!ctl_in_ready) @(negedge clk);
    ctl_in_valid = 1'b1; ctl_in_data = b;
    @(negedge clk);
    ctl_in_valid = 1'b0;
  endtask

  task automatic ctl_pop(output logic [7:0] b);
    @(negedge clk);
    while (!ctl_out_valid) @(negedge clk);
    b = ctl_out_data;
    ctl_out_ready = 1'b1;
    @(negedge clk);
    ctl_out_ready = 1'b0;
  endtask

  task automatic cpu_access(input bit is_rd, input logic [15:0] a, input logic [7:0] wd,
                            output logic [7:0] rdv, output logic vld, output int waits);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = wd;
    if (is_rd) cpu_rd = 1'b1; else cpu_wr = 1'b1;
    @(negedge clk);
    waits = 0;
    while (!cpu_wait_n && waits < 2000) begin waits++; @(negedge clk); end
    rdv = cpu_rdata; vld = cpu_rdata_vld;
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] rv, pv, b;
    logic       vl;
    int         w;
    void'($urandom(32'd20241));

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2 reset state
    check(ctl_in_ready == 1'b1,  "R2 in_ready", ctl_in_ready, 1);
    check(ctl_out_valid == 1'b0, "R2 out_valid", ctl_out_valid, 0);
    check(cpu_wait_n == 1'b1,    "R2 wait_n", cpu_wait_n, 1);
    check(cpu_rdata_vld == 1'b0, "R2 rdata_vld", cpu_rdata_vld, 0);
    check(link_up == 1'b0 && cpu_alive == 1'b0, "R2 link", {link_up, cpu_alive}, 0);

    // R7 connect refused while controller not alive
    pulse_connect();
    check(link_up == 1'b0 && cpu_alive == 1'b0, "R7 refused", {link_up, cpu_alive}, 0);

    // R10 access while not connected
    ctl_push(8'h5A);
    cpu_access(1'b1, port_addr(8'h00), 8'h00, rv, vl, w);
    check(rv == 8'h00 && vl == 1'b0 && w == 0, "R10 read zero", {rv, vl}, 0);
    check(ctl_in_ready == 1'b0, "R10 byte kept", ctl_in_ready, 0);
    cpu_access(1'b0, port_addr(8'h00), 8'h77, rv, vl, w);
    check(ctl_out_valid == 1'b0 && w == 0, "R10 write discarded", ctl_out_valid, 0);

    // R7 connect with controller alive
    ctl_alive = 1'b1;
    pulse_connect();
    check(link_up == 1'b1 && cpu_alive == 1'b1, "R7 connect", {link_up, cpu_alive}, 3);

    // R1 non-decoded low byte is ignored
    cpu_access(1'b1, 16'h00EE, 8'h00, rv, vl, w);
    check(vl == 1'b0 && ctl_in_ready == 1'b0 && w == 0, "R1 miss read", {vl, ctl_in_ready}, 0);
    cpu_access(1'b0, 16'h01EF ^ 16'h0010, 8'h11, rv, vl, w);
    check(ctl_out_valid == 1'b0, "R1 miss write", ctl_out_valid, 0);

    // R1 R3 upper byte ignored, read of full channel
    cpu_access(1'b1, port_addr(8'hC3), 8'h00, rv, vl, w);
    check(rv == 8'h5A && vl == 1'b1 && w == 0, "R3 read byte", rv, 8'h5A);
    check(ctl_in_ready == 1'b1, "R3 emptied", ctl_in_ready, 1);

    // R4 write
    cpu_access(1'b0, port_addr(8'h12), 8'hA7, rv, vl, w);
    check(ctl_out_valid == 1'b1 && ctl_out_data == 8'hA7 && w == 0, "R4 write", ctl_out_data, 8'hA7);
    repeat (3) @(negedge clk);
    check(ctl_out_valid == 1'b1 && ctl_out_data == 8'hA7, "R4 hold", ctl_out_data, 8'hA7);

    // R6 write waits on full outbound channel
    fork
      cpu_access(1'b0, port_addr(8'h00), 8'h3B, rv, vl, w);
      begin repeat (6) @(negedge clk); ctl_pop(b); end
    join
    check(b == 8'hA7, "R6 first byte", b, 8'hA7);
    check(w > 0, "R6 waited", w, 1);
    ctl_pop(b);
    check(b == 8'h3B, "R6 second byte", b, 8'h3B);

    // R5 read waits on empty inbound channel
    fork
      cpu_access(1'b1, port_addr(8'hFF), 8'h00, rv, vl, w);
      begin repeat (6) @(negedge clk); ctl_push(8'hC4); end
    join
    check(w > 0, "R5 waited", w, 1);
    check(rv == 8'hC4 && vl == 1'b1, "R5 data", rv, 8'hC4);

    // R11 one byte per bus cycle
    ctl_push(8'h21);
    @(negedge clk);
    cpu_addr = port_addr(8'h40); cpu_rd = 1'b1;
    repeat (2) @(negedge clk);
    ctl_push(8'h22);
    repeat (3) @(negedge clk);
    check(ctl_in_ready == 1'b0 && cpu_rdata == 8'h21, "R11 no second pop", cpu_rdata, 8'h21);
    cpu_rd = 1'b0;
    @(negedge clk);
    cpu_access(1'b1, port_addr(8'h40), 8'h00, rv, vl, w);
    check(rv == 8'h22 && vl == 1'b1, "R11 next read", rv, 8'h22);

    // random traffic, R3 R4
    for (int i = 0; i < 60; i++) begin
      pv = 8'($urandom);
      if ($urandom_range(0, 1) == 0) begin
        cpu_access(1'b0, port_addr(8'($urandom)), pv, rv, vl, w);
        ctl_pop(b);
        check(b == pv && w == 0, "R4 random write", b, pv);
      end else begin
        ctl_push(pv);
        cpu_access(1'b1, port_addr(8'($urandom)), 8'h00, rv, vl, w);
        check(rv == pv && vl == 1'b1 && w == 0, "R3 random read", rv, pv);
      end
    end

    // R9 loss of link during a stalled read
    fork
      cpu_access(1'b1, port_addr(8'h00), 8'h00, rv, vl, w);
      begin repeat (5) @(negedge clk); ctl_alive = 1'b0; end
    join
    check(rv == 8'h00 && vl == 1'b0, "R9 read zero", {rv, vl}, 0);
    check(link_up == 1'b0, "R9 link cleared", link_up, 0);

    // R9 write while peer dead
    ctl_alive = 1'b1;
    pulse_connect();
    ctl_alive = 1'b0;
    cpu_access(1'b0, port_addr(8'h00), 8'h99, rv, vl, w);
    check(ctl_out_valid == 1'b0 && link_up == 1'b0 && w == 0, "R9 write dropped",
          {ctl_out_valid, link_up}, 0);

    // R8 drop clears both, drop beats connect
    ctl_alive = 1'b1;
    pulse_connect();
    pulse_drop();
    check(link_up == 1'b0 && cpu_alive == 1'b0, "R8 drop", {link_up, cpu_alive}, 0);
    @(negedge clk); link_connect = 1'b1; link_drop = 1'b1;
    @(negedge clk); link_connect = 1'b0; link_drop = 1'b0;
    check(link_up == 1'b0, "R8 drop priority", link_up, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule